// File: doc/BRIEF.md
# Noise-Shaping Requantizer with Segmented DAC Encoder

This block sits between the up-sampling interpolator and the analog current cells of one audio channel, and one copy is used per channel. Each time the four-times-sample-rate enable is high, it takes a 22-bit two's complement sample and cuts it to 15 bits. It uses first-order error feedback, so the seven bits that truncation drops are carried into the next sample and are not lost.

The 15-bit word is then turned into the control fields of a segmented current DAC. A direction bit steers the output current. A 32-line thermometer code switches on whole coarse current sources. A 9-bit selector picks the fraction of one more coarse source that passes through a 512-element fine matrix. All three fields are held in an output latch that loads only on the enable, so the analog side sees a steady code between updates.

Top module: `ns_seg_dac_enc`

## Requirements
- R1: While rst_ni is low, and after it goes low at any time, dir_o, therm_o and fine_o are all zero and the stored truncation error is zero. The first enabled sample after reset therefore sees no carried error.
- R2: The outputs change only on a rising clock edge at which en_i is high, and they show that sample's result right after that edge. While en_i is low they hold their value whatever sample_i does.
- R3: The 15-bit word is floor((sample_i + e) / 128), where e is the stored error and sample_i is read as signed.
- R4: On every enabled sample that does not saturate, the stored error becomes the low 7 bits of (sample_i + e), read as unsigned 0..127. It keeps its value while en_i is low.
- R5: If (sample_i + e) / 128 would be above 16383, the word is clamped to 16383 and the stored error is cleared to 0.
- R6: dir_o is 1 exactly when the 15-bit word is negative.
- R7: The magnitude is the absolute value of the word, with -16384 clipped to 16383. fine_o is magnitude bits [8:0].
- R8: The coarse count k is magnitude bits [13:9]. therm_o bit i is 1 for every i < k and 0 otherwise, so bit 31 is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Four-times-sample-rate update strobe |
| sample_i | input | 22 | Two's complement interpolated sample |
| dir_o | output | 1 | Current direction, 1 for a negative word |
| therm_o | output | 32 | Coarse source enables, thermometer coded |
| fine_o | output | 9 | Fine matrix selector |

## Verification
Small positive inputs below one output step are sent in a row. They show that the output only steps up once enough carried error has built up, which separates error feedback from plain truncation. Full-scale positive input following a non-zero residue, and then an input just short of one step, show that saturation clears the error. Negative inputs that round toward minus infinity, the most negative input, and mid-range values on both signs check the direction bit, the clip of the magnitude and the split between the coarse and fine fields. Idle periods with a changing input, and a reset in the middle of a run, show that the latch and the error are held or cleared as R2 and R1 require.

// File: rtl/ns_seg_dac_pkg.sv
package ns_seg_dac_pkg;
  localparam int unsigned DEF_IN_W     = 22;
  localparam int unsigned DEF_OUT_W    = 15;
  localparam int unsigned DEF_COARSE_W = 5;
  localparam int unsigned DEF_FINE_W   = 9;
endpackage

// File: rtl/ns_err_shaper.sv
module ns_err_shaper #(
  parameter int unsigned IN_W  = ns_seg_dac_pkg::DEF_IN_W,
  parameter int unsigned OUT_W = ns_seg_dac_pkg::DEF_OUT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [IN_W-1:0]  sample_i,
  output logic [OUT_W-1:0] word_o
);
  localparam int unsigned ERR_W = IN_W - OUT_W;
  localparam int unsigned SUM_W = IN_W + 1;
  localparam logic [OUT_W-1:0] W_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] W_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [ERR_W-1:0] err_q, err_d;
  logic [SUM_W-1:0] sum;
  logic [OUT_W:0]   hi;
  logic             ovf;

  always_comb begin
    sum   = {sample_i[IN_W-1], sample_i} + {1'b0, {(IN_W-ERR_W){1'b0}}, err_q};
    hi    = sum[SUM_W-1:ERR_W];
    ovf   = hi[OUT_W] ^ hi[OUT_W-1];
    if (ovf) begin
      word_o = hi[OUT_W] ? W_MIN : W_MAX;
      err_d  = '0;
    end else begin
      word_o = hi[OUT_W-1:0];
      err_d  = sum[ERR_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   err_q <= '0;
    else if (en_i) err_q <= err_d;
  end
endmodule

// File: rtl/ns_sm_split.sv
module ns_sm_split #(
  parameter int unsigned OUT_W = ns_seg_dac_pkg::DEF_OUT_W,
  localparam int unsigned MAG_W = OUT_W - 1
) (
  input  logic [OUT_W-1:0] word_i,
  output logic             sign_o,
  output logic [MAG_W-1:0] mag_o
);
  logic [MAG_W-1:0] low, neg;

  always_comb begin
    low    = word_i[MAG_W-1:0];
    sign_o = word_i[OUT_W-1];
    neg    = MAG_W'(~low + 1'b1);
    if (!sign_o)        mag_o = low;
    else if (low == '0) mag_o = '1;   // most negative word: clip
    else                mag_o = neg;
  end
endmodule

// File: rtl/ns_therm_dec.sv
module ns_therm_dec #(
  parameter int unsigned K_W = ns_seg_dac_pkg::DEF_COARSE_W,
  localparam int unsigned N_LINES = 1 << K_W
) (
  input  logic [K_W-1:0]     code_i,
  output logic [N_LINES-1:0] therm_o
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign therm_o[i] = (code_i > K_W'(i));
  end
endmodule

// File: rtl/ns_seg_dac_enc.sv
module ns_seg_dac_enc #(
  parameter int unsigned IN_W     = ns_seg_dac_pkg::DEF_IN_W,
  parameter int unsigned OUT_W    = ns_seg_dac_pkg::DEF_OUT_W,
  parameter int unsigned COARSE_W = ns_seg_dac_pkg::DEF_COARSE_W,
  parameter int unsigned FINE_W   = ns_seg_dac_pkg::DEF_FINE_W,
  localparam int unsigned MAG_W   = OUT_W - 1,
  localparam int unsigned N_LINES = 1 << COARSE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [IN_W-1:0]    sample_i,
  output logic               dir_o,
  output logic [N_LINES-1:0] therm_o,
  output logic [FINE_W-1:0]  fine_o
);
  initial begin
    if (MAG_W != COARSE_W + FINE_W) $error("segment widths do not match magnitude");
  end

  logic [OUT_W-1:0]   word;
  logic               sign;
  logic [MAG_W-1:0]   mag;
  logic [N_LINES-1:0] therm;

  ns_err_shaper #(.IN_W(IN_W), .OUT_W(OUT_W)) shaper_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sample_i(sample_i), .word_o(word)
  );

  ns_sm_split #(.OUT_W(OUT_W)) split_i (
    .word_i(word), .sign_o(sign), .mag_o(mag)
  );

  ns_therm_dec #(.K_W(COARSE_W)) therm_i (
    .code_i(mag[MAG_W-1:FINE_W]), .therm_o(therm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o   <= 1'b0;
      therm_o <= '0;
      fine_o  <= '0;
    end else if (en_i) begin
      dir_o   <= sign;
      therm_o <= therm;
      fine_o  <= mag[FINE_W-1:0];
    end
  end
endmodule

// File: rtl/ns_seg_dac_enc_chk.sv
module ns_seg_dac_enc_chk #(
  parameter int unsigned IN_W    = 22,
  parameter int unsigned N_LINES = 32,
  parameter int unsigned FINE_W  = 9
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [IN_W-1:0]    sample_i,
  input logic               dir_o,
  input logic [N_LINES-1:0] therm_o,
  input logic [FINE_W-1:0]  fine_o
);
  localparam logic [IN_W-1:0]    S_MAX = {1'b0, {(IN_W-1){1'b1}}};
  localparam logic [IN_W-1:0]    S_MIN = {1'b1, {(IN_W-1){1'b0}}};
  localparam logic [N_LINES-1:0] T_FULL = {1'b0, {(N_LINES-1){1'b1}}};

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable({dir_o, therm_o, fine_o}));

  a_r8_therm_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((therm_o + 1'b1) & therm_o) == '0) && !therm_o[N_LINES-1]);

  a_r6_no_neg_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_o == '0 && fine_o == '0) |-> !dir_o);

  a_r4_zero_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sample_i == '0) |=> (!dir_o && therm_o == '0 && fine_o == '0));

  a_r5_pos_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sample_i == S_MAX) |=> (!dir_o && therm_o == T_FULL && fine_o == '1));

  a_r7_neg_clip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sample_i == S_MIN) |=> (dir_o && therm_o == T_FULL && fine_o == '1));
endmodule

bind ns_seg_dac_enc ns_seg_dac_enc_chk #(
  .IN_W(IN_W), .N_LINES(N_LINES), .FINE_W(FINE_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sample_i(sample_i),
  .dir_o(dir_o), .therm_o(therm_o), .fine_o(fine_o)
);

// File: tb/ns_seg_dac_enc_tb_top.sv
module ns_seg_dac_enc_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [21:0] sample_i = '0;
  logic        dir_o;
  logic [31:0] therm_o;
  logic [8:0]  fine_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  ns_seg_dac_enc dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sample_i(sample_i),
    .dir_o(dir_o), .therm_o(therm_o), .fine_o(fine_o)
  );

  localparam int NV = 13;
  localparam logic [21:0] VEC_S [NV] = '{
    22'd0, 22'd200, 22'd100, 22'd100, 22'd120, 22'h1FFFFF, 22'd121,
    22'h1FFFFF, 22'd0, 22'h3FFF80, 22'h200000, 22'd328128, 22'h3CFC80};
  localparam bit VEC_D [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 1};
  localparam int VEC_K [NV] = '{0, 0, 0, 0, 0, 31, 0, 31, 0, 0, 31, 5, 3};
  localparam int VEC_F [NV] = '{0, 1, 1, 1, 1, 511, 0, 511, 0, 1, 511, 3, 7};
  localparam string VEC_T [NV] = '{
    "R3 zero", "R3 one step", "R4 carry", "R4 carry", "R4 carry lifts small input",
    "R5 sat", "R5 error cleared", "R5 sat", "R3 zero", "R6 floor negative",
    "R7 clip", "R8 mid positive", "R8 mid negative"};

  task automatic check(input string tag, input bit d, input int k, input int f);
    logic [31:0] exp_t;
    exp_t = 32'((64'd1 << k) - 64'd1);
    n_chk++;
    if (dir_o !== d || therm_o !== exp_t || fine_o !== 9'(f)) begin
      n_fail++;
      $display("FAIL %s: got dir=%0b therm=%h fine=%0d, want dir=%0b therm=%h fine=%0d",
               tag, dir_o, therm_o, fine_o, d, exp_t, f);
    end
  endtask

  task automatic apply(input logic [21:0] s);
    @(negedge clk_i);
    sample_i = s;
    en_i = 1'b1;
    @(negedge clk_i);
    en_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset state", 0, 0, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      apply(VEC_S[i]);
      check(VEC_T[i], VEC_D[i], VEC_K[i], VEC_F[i]);
    end

    // R2: idle with changing input holds the latch
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      sample_i = 22'h0AAAAA + 22'(i * 977);
    end
    @(negedge clk_i);
    check("R2 hold while idle", 1, 3, 7);

    // R4: residue 64 kept through idle: 63 -> 0, then 1 -> step
    apply(22'd63);
    check("R4 residue kept", 0, 0, 0);
    apply(22'd1);
    check("R4 residue carried", 0, 0, 1);

    // R1: mid-run reset clears error and latch
    apply(22'd200);
    check("R3 before reset", 0, 0, 1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    check("R1 async reset", 0, 0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(22'd100);
    check("R1 error cleared by reset", 0, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule